// File: doc/BRIEF.md
# Ring Command Packet Decoder

The block consumes a stream of 32-bit command words held in a circular ring in memory. It fetches words one at a time through a valid/ready memory port, between a read pointer that it owns and a write pointer that the producer supplies. It decodes type-3 packet headers and carries out a small set of packets. A set-register packet writes consecutive entries of a register file. A conditional wait compares a masked value with a reference. A release writes either a 64-bit value or a free-running timestamp to memory. An indirect packet fetches one level of nested commands from a second buffer. Acquire and event-write packets are skipped.

When a conditional wait fails, the decoder moves its read pointer back to that packet's header and pauses. A retry pulse makes it fetch and evaluate the whole packet again. An indirect packet moves fetching to a separate base, pointer and size, and ring fetching resumes only after that buffer is drained. A malformed header, an unknown opcode, a bad body count or an unsupported selector stops the decoder for good and raises a sticky error.

Top module: `ring_pkt_decoder`

## Requirements
- R1: After reset, rptr_o is 0, error_o and paused_o are 0, idle_o is 1 while wptr_i is 0, and neither mem_req_o nor reg_we_o is asserted.
- R2: A packet header is fetched only while rptr_o < wptr_i. The read address is ring_base_i + (rptr_o mod RING_DEPTH), so packets that cross the end of the ring wrap to its base. rptr_o only steps by +1 per fetched word or by -7 on a rewind.
- R3: A header's bits 31:30 must hold 3. Any other value makes error_o 1, and the decoder stops with rptr_o just past that header.
- R4: Header bits 15:8 are the opcode and bits 29:16 the body count n. An opcode matching no parameter, or a wait with n other than 5, or a release or acquire with n other than 6, or an event write with n other than 0, sets error_o. error_o stays set and no further memory or register access happens until reset.
- R5: A set-register packet carries an offset word and then n data words. Data word k is written to register offset+k, one reg_we_o pulse per word, in order.
- R6: Wait body: info, address low, address high (ignored), reference, mask, timeout (ignored). Info bit 4 = 1 reads the value from the dword at the address; 0 uses the reference itself. Info bits 2:0 = 3 pass when (value & mask) == reference, and 5 pass when (value & mask) >= reference. Other functions set error_o.
- R7: A failed wait sets rptr_o back by 7 to the packet header and asserts paused_o. rptr_o holds until a retry_i pulse, after which the packet is fetched and evaluated again.
- R8: Release body: event word (event type in bits 7:0), selector word (bits 31:29), address low, address high (ignored), value low, value high, a trailing word. Selector 1 or 2 writes value low to the address and value high to address+1.
- R9: Release selector 3 with event type 0x14 writes the free-running cycle counter, low half then high half, as in R8. Any other selector or event combination sets error_o.
- R10: Indirect body: base low, base high (ignored), size in dwords from bits 22:0 of the third word. The buffer is fetched from base, and all its words are processed before the ring resumes. An indirect packet inside an indirect buffer sets error_o.
- R11: An acquire packet (7 body words) and an event write (1 body word) only advance the read position and produce no memory write or register write.
- R12: A memory request keeps address, write enable and write data stable until mem_ready_i, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ring_base_i | input | AW | Dword address of the ring start |
| wptr_i | input | PW | Producer write pointer in dwords (absolute) |
| retry_i | input | 1 | Pulse to re-evaluate a paused wait |
| rptr_o | output | PW | Ring read pointer in dwords (absolute) |
| idle_o | output | 1 | No ring or indirect work pending |
| paused_o | output | 1 | A failed wait is parked |
| error_o | output | 1 | Sticky error, decoder halted |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Dword address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| reg_we_o | output | 1 | Register file write strobe |
| reg_addr_o | output | RAW | Register offset |
| reg_wdata_o | output | 32 | Register data |

## Verification
The bench builds the decoder with RING_DEPTH of 16. A release packet written at ring position 14 then wraps across the ring end, and several phases reuse ring slots, all within a few dozen words. The opcodes are passed explicitly with their default values, and AW, PW and RAW keep their defaults of 32, 32 and 16. A 12-bit memory model serves every address used. Its ready line drops one cycle in four, so requests that stall on the handshake and the single outstanding read are covered by every packet.

// File: rtl/ring_pkt_pkg.sv
package ring_pkt_pkg;
  typedef enum logic [3:0] {
    S_FETCH, S_RDWAIT, S_EXEC, S_WREAD, S_WRDATA, S_CMP, S_PAUSE, S_WR0, S_WR1, S_HALT
  } rpd_state_e;

  typedef enum logic [2:0] {
    K_SETREG, K_WAIT, K_REL, K_IB, K_ACQ, K_EVT, K_NONE
  } pkt_kind_e;

  localparam logic [2:0] FN_EQ    = 3'd3;
  localparam logic [2:0] FN_GEQ   = 3'd5;
  localparam logic [7:0] TS_EVENT = 8'h14;
  localparam int unsigned TS_W    = 64;
endpackage

// File: rtl/rpd_hdr.sv
module rpd_hdr import ring_pkt_pkg::*; #(
  parameter logic [7:0] OP_SETREG = 8'h76,
  parameter logic [7:0] OP_WAIT   = 8'h3c,
  parameter logic [7:0] OP_REL    = 8'h49,
  parameter logic [7:0] OP_IB     = 8'h3f,
  parameter logic [7:0] OP_ACQ    = 8'h58,
  parameter logic [7:0] OP_EVT    = 8'h46
) (
  input  logic [23:0] hdr_i,      // header word bits 31:8
  output logic        type_ok_o,
  output pkt_kind_e   kind_o,
  output logic        len_ok_o,
  output logic [15:0] len_o
);
  logic [13:0] n;
  logic [7:0]  op;
  assign n  = hdr_i[21:8];
  assign op = hdr_i[7:0];
  assign type_ok_o = (hdr_i[23:22] == 2'd3);

  always_comb begin
    if      (op == OP_SETREG) kind_o = K_SETREG;
    else if (op == OP_WAIT)   kind_o = K_WAIT;
    else if (op == OP_REL)    kind_o = K_REL;
    else if (op == OP_IB)     kind_o = K_IB;
    else if (op == OP_ACQ)    kind_o = K_ACQ;
    else if (op == OP_EVT)    kind_o = K_EVT;
    else                      kind_o = K_NONE;
  end

  always_comb begin
    len_ok_o = 1'b1;
    len_o    = 16'd1;
    unique case (kind_o)
      K_SETREG: len_o = 16'(n) + 16'd1;
      K_WAIT:   begin len_ok_o = (n == 14'd5); len_o = 16'd6; end
      K_REL:    begin len_ok_o = (n == 14'd6); len_o = 16'd7; end
      K_IB:     len_o = 16'd3;
      K_ACQ:    begin len_ok_o = (n == 14'd6); len_o = 16'd7; end
      K_EVT:    begin len_ok_o = (n == 14'd0); len_o = 16'd1; end
      default:  len_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rpd_cmp.sv
module rpd_cmp import ring_pkt_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic [2:0]    func_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] ref_i,
  input  logic [DW-1:0] mask_i,
  output logic          pass_o,
  output logic          bad_o
);
  logic [DW-1:0] masked;
  assign masked = val_i & mask_i;

  always_comb begin
    pass_o = 1'b0;
    bad_o  = 1'b0;
    if      (func_i == FN_EQ)  pass_o = (masked == ref_i);
    else if (func_i == FN_GEQ) pass_o = (masked >= ref_i);
    else                       bad_o  = 1'b1;
  end
endmodule

// File: rtl/rpd_tstamp.sv
module rpd_tstamp #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/ring_pkt_decoder.sv
module ring_pkt_decoder import ring_pkt_pkg::*; #(
  parameter int unsigned AW         = 32,
  parameter int unsigned PW         = 32,
  parameter int unsigned RAW        = 16,
  parameter int unsigned RING_DEPTH = 1024,   // power of two, dwords
  parameter logic [7:0]  OP_SETREG  = 8'h76,
  parameter logic [7:0]  OP_WAIT    = 8'h3c,
  parameter logic [7:0]  OP_REL     = 8'h49,
  parameter logic [7:0]  OP_IB      = 8'h3f,
  parameter logic [7:0]  OP_ACQ     = 8'h58,
  parameter logic [7:0]  OP_EVT     = 8'h46
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  ring_base_i,
  input  logic [PW-1:0]  wptr_i,
  input  logic           retry_i,
  output logic [PW-1:0]  rptr_o,
  output logic           idle_o,
  output logic           paused_o,
  output logic           error_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [31:0]    mem_wdata_o,
  input  logic           mem_ready_i,
  input  logic           mem_rvalid_i,
  input  logic [31:0]    mem_rdata_i,
  output logic           reg_we_o,
  output logic [RAW-1:0] reg_addr_o,
  output logic [31:0]    reg_wdata_o
);
  localparam logic [PW-1:0] RING_MASK = PW'(RING_DEPTH - 1);
  localparam logic [PW-1:0] REWIND    = PW'(7);

  rpd_state_e     st_q;
  pkt_kind_e      kind_q;
  logic [PW-1:0]  rptr_q, ib_rptr_q, ib_size_q;
  logic [AW-1:0]  ib_base_q, w_addr_q;
  logic           in_ib_q, in_pkt_q;
  logic [15:0]    idx_q, rem_q;
  logic [31:0]    word_q, w_ref_q, w_mask_q, meas_q, vlo_q, vhi_q, wr_lo_q, wr_hi_q;
  logic [RAW-1:0] reg_off_q;
  logic [2:0]     w_func_q, r_sel_q;
  logic           w_mem_q;
  logic [7:0]     r_evt_q;

  // header decode, compare, timestamp
  logic        hdr_type_ok, hdr_len_ok;
  pkt_kind_e   hdr_kind;
  logic [15:0] hdr_len;
  logic        cmp_pass, cmp_bad;
  logic [TS_W-1:0] ts;

  rpd_hdr #(
    .OP_SETREG(OP_SETREG), .OP_WAIT(OP_WAIT), .OP_REL(OP_REL),
    .OP_IB(OP_IB), .OP_ACQ(OP_ACQ), .OP_EVT(OP_EVT)
  ) u_hdr (
    .hdr_i(word_q[31:8]), .type_ok_o(hdr_type_ok), .kind_o(hdr_kind),
    .len_ok_o(hdr_len_ok), .len_o(hdr_len)
  );

  rpd_cmp #(.DW(32)) u_cmp (
    .func_i(w_func_q), .val_i(meas_q), .ref_i(w_ref_q), .mask_i(w_mask_q),
    .pass_o(cmp_pass), .bad_o(cmp_bad)
  );

  rpd_tstamp #(.W(TS_W)) u_ts (.clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(ts));

  // fetch source
  logic [PW-1:0] cur_ptr, cur_lim;
  logic [AW-1:0] fetch_addr;
  logic          have_word, last_body;

  assign cur_ptr    = in_ib_q ? ib_rptr_q : rptr_q;
  assign cur_lim    = in_ib_q ? ib_size_q : wptr_i;
  assign have_word  = cur_ptr < cur_lim;
  assign fetch_addr = in_ib_q ? ib_base_q + AW'(ib_rptr_q)
                              : ring_base_i + AW'(rptr_q & RING_MASK);
  assign last_body  = (rem_q == 16'd1);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = fetch_addr;
    mem_wdata_o = wr_lo_q;
    unique case (st_q)
      S_FETCH: mem_req_o = in_pkt_q || have_word;
      S_WREAD: begin mem_req_o = 1'b1; mem_addr_o = w_addr_q; end
      S_WR0:   begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = w_addr_q; end
      S_WR1:   begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = w_addr_q + AW'(1); mem_wdata_o = wr_hi_q;
      end
      default: ;
    endcase
  end

  assign reg_we_o    = (st_q == S_EXEC) && in_pkt_q && (kind_q == K_SETREG) && (idx_q != 16'd0);
  assign reg_addr_o  = reg_off_q + RAW'(idx_q - 16'd1);
  assign reg_wdata_o = word_q;
  assign rptr_o      = rptr_q;
  assign paused_o    = (st_q == S_PAUSE);
  assign error_o     = (st_q == S_HALT);
  assign idle_o      = (st_q == S_FETCH) && !in_pkt_q && !in_ib_q && !have_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_FETCH;     kind_q <= K_NONE;
      rptr_q <= '0;        ib_rptr_q <= '0;   ib_size_q <= '0;
      ib_base_q <= '0;     w_addr_q <= '0;
      in_ib_q <= 1'b0;     in_pkt_q <= 1'b0;
      idx_q <= '0;         rem_q <= '0;
      word_q <= '0;        w_ref_q <= '0;     w_mask_q <= '0;  meas_q <= '0;
      vlo_q <= '0;         vhi_q <= '0;       wr_lo_q <= '0;   wr_hi_q <= '0;
      reg_off_q <= '0;     w_func_q <= '0;    r_sel_q <= '0;
      w_mem_q <= 1'b0;     r_evt_q <= '0;
    end else begin
      unique case (st_q)
        S_FETCH: begin
          if (!in_pkt_q && !have_word && in_ib_q) begin
            in_ib_q <= 1'b0;                 // indirect buffer drained
          end else if (mem_req_o && mem_ready_i) begin
            if (in_ib_q) ib_rptr_q <= ib_rptr_q + PW'(1);
            else         rptr_q    <= rptr_q + PW'(1);
            st_q <= S_RDWAIT;
          end
        end
        S_RDWAIT: if (mem_rvalid_i) begin
          word_q <= mem_rdata_i;
          st_q   <= S_EXEC;
        end
        S_EXEC: begin
          if (!in_pkt_q) begin
            if (!hdr_type_ok || hdr_kind == K_NONE || !hdr_len_ok) begin
              st_q <= S_HALT;
            end else begin
              kind_q <= hdr_kind; rem_q <= hdr_len; idx_q <= '0;
              in_pkt_q <= 1'b1;   st_q <= S_FETCH;
            end
          end else begin
            idx_q <= idx_q + 16'd1;
            rem_q <= rem_q - 16'd1;
            st_q  <= S_FETCH;
            if (last_body) in_pkt_q <= 1'b0;
            unique case (kind_q)
              K_SETREG: if (idx_q == 16'd0) reg_off_q <= word_q[RAW-1:0];
              K_WAIT: begin
                case (idx_q)
                  16'd0: begin w_func_q <= word_q[2:0]; w_mem_q <= word_q[4]; end
                  16'd1: w_addr_q <= AW'(word_q);
                  16'd3: w_ref_q  <= word_q;
                  16'd4: w_mask_q <= word_q;
                  16'd5: begin
                    meas_q <= w_ref_q;
                    st_q   <= w_mem_q ? S_WREAD : S_CMP;
                  end
                  default: ;
                endcase
              end
              K_REL: begin
                case (idx_q)
                  16'd0: r_evt_q  <= word_q[7:0];
                  16'd1: r_sel_q  <= word_q[31:29];
                  16'd2: w_addr_q <= AW'(word_q);
                  16'd4: vlo_q    <= word_q;
                  16'd5: vhi_q    <= word_q;
                  16'd6: begin
                    if (r_sel_q == 3'd1 || r_sel_q == 3'd2) begin
                      wr_lo_q <= vlo_q; wr_hi_q <= vhi_q; st_q <= S_WR0;
                    end else if (r_sel_q == 3'd3 && r_evt_q == TS_EVENT) begin
                      wr_lo_q <= ts[31:0]; wr_hi_q <= ts[63:32]; st_q <= S_WR0;
                    end else begin
                      st_q <= S_HALT;
                    end
                  end
                  default: ;
                endcase
              end
              K_IB: begin
                case (idx_q)
                  16'd0: w_addr_q <= AW'(word_q);
                  16'd2: begin
                    if (in_ib_q) begin
                      st_q <= S_HALT;          // one nesting level only
                    end else begin
                      ib_base_q <= w_addr_q;
                      ib_size_q <= PW'(word_q[22:0]);
                      ib_rptr_q <= '0;
                      in_ib_q   <= 1'b1;
                    end
                  end
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
        end
        S_WREAD:  if (mem_ready_i) st_q <= S_WRDATA;
        S_WRDATA: if (mem_rvalid_i) begin
          meas_q <= mem_rdata_i;
          st_q   <= S_CMP;
        end
        S_CMP: begin
          if (cmp_bad) begin
            st_q <= S_HALT;
          end else if (cmp_pass) begin
            st_q <= S_FETCH;
          end else begin
            if (in_ib_q) ib_rptr_q <= ib_rptr_q - REWIND;
            else         rptr_q    <= rptr_q - REWIND;
            st_q <= S_PAUSE;
          end
        end
        S_PAUSE: if (retry_i) st_q <= S_FETCH;
        S_WR0:   if (mem_ready_i) st_q <= S_WR1;
        S_WR1:   if (mem_ready_i) st_q <= S_FETCH;
        S_HALT:  ;
        default: st_q <= S_HALT;
      endcase
    end
  end

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rptr_q != $past(rptr_q)) |->
      (rptr_q == $past(rptr_q) + PW'(1) || rptr_q == $past(rptr_q) - REWIND));

  // R4
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  // R4
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!mem_req_o && !reg_we_o));

  // R7
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && !retry_i) |=> (paused_o && $stable(rptr_o)));

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/ring_pkt_decoder_test.sv
module ring_pkt_decoder_test;
  localparam logic [7:0] O_SET = 8'h76, O_WAIT = 8'h3c, O_REL = 8'h49,
                         O_IB = 8'h3f, O_ACQ = 8'h58, O_EVT = 8'h46;
  localparam logic [31:0] RB = 32'h100;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wptr = '0;
  logic        retry = 1'b0;
  logic [31:0] rptr;
  logic        idle, paused, err;
  logic        mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        reg_we;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;

  always #10 clk = ~clk;   // 50 MHz

  ring_pkt_decoder #(
    .AW(32), .PW(32), .RAW(16), .RING_DEPTH(DEPTH),
    .OP_SETREG(O_SET), .OP_WAIT(O_WAIT), .OP_REL(O_REL),
    .OP_IB(O_IB), .OP_ACQ(O_ACQ), .OP_EVT(O_EVT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(RB), .wptr_i(wptr), .retry_i(retry),
    .rptr_o(rptr), .idle_o(idle), .paused_o(paused), .error_o(err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata)
  );

  // memory model: ready drops one cycle in four, reads answer next cycle
  logic [31:0] mem [0:4095];
  logic [1:0]  rdy_cnt = '0;
  logic        h_we = 1'b0;
  logic [31:0] h_addr = '0, h_data = '0;
  assign mem_ready = (rdy_cnt != 2'd3);

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 2'd1;
    if (h_we) mem[h_addr[11:0]] <= h_data;
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= mem_req && !mem_we && mem_ready;
      mem_rdata  <= mem[mem_addr[11:0]];
      if (mem_req && mem_we && mem_ready) mem[mem_addr[11:0]] <= mem_wdata;
    end
  end

  // observer: records effects every clock, checks handshake stability
  logic [15:0] obs_ra[$];
  logic [31:0] obs_rd[$], obs_ma[$], obs_md[$];
  int          obs_rc[$], obs_mc[$];
  int          cyc = 0, mon_chk = 0, mon_fail = 0;
  logic        hold_prev = 1'b0, we_prev = 1'b0;
  logic [31:0] addr_prev = '0, data_prev = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; hold_prev = 1'b0;
    end else begin
      cyc++;
      if (reg_we) begin obs_ra.push_back(reg_addr); obs_rd.push_back(reg_wdata); obs_rc.push_back(cyc); end
      if (mem_req && mem_we && mem_ready) begin
        obs_ma.push_back(mem_addr); obs_md.push_back(mem_wdata); obs_mc.push_back(cyc);
      end
      if (hold_prev) begin
        mon_chk++;
        if (!(mem_req && mem_addr == addr_prev && mem_we == we_prev && mem_wdata == data_prev)) begin
          mon_fail++;
          $display("FAIL R12 request changed while stalled: addr %0h exp %0h", mem_addr, addr_prev);
        end
      end
      hold_prev = mem_req && !mem_ready;
      addr_prev = mem_addr; we_prev = mem_we; data_prev = mem_wdata;
    end
  end

  int n_chk = 0, n_fail = 0, ri = 0, mi = 0, wp = 0, ib_wp = 0;
  bit to_ib = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [1:0] t, input int n, input logic [7:0] op);
    return {t, n[13:0], op, 8'h00};
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a; h_data = d;
    @(posedge clk); #1 h_we = 1'b0;
  endtask

  task automatic emit(input logic [31:0] w);
    if (to_ib) begin put(32'(ib_wp), w); ib_wp++; end
    else begin put(RB + 32'(wp % DEPTH), w); wp++; end
  endtask

  task automatic go();
    @(negedge clk); wptr = 32'(wp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000 && !(idle || paused || err); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic exp_reg(input logic [15:0] a, input logic [31:0] d, input string req);
    if (ri >= obs_ra.size()) chk(1'b0, req, "missing register write", 0, longint'(a));
    else begin
      chk(obs_ra[ri] == a, req, "register offset", longint'(obs_ra[ri]), longint'(a));
      chk(obs_rd[ri] == d, req, "register data", longint'(obs_rd[ri]), longint'(d));
    end
    ri++;
  endtask

  task automatic exp_mem(input logic [31:0] a, input logic [31:0] d, input string req);
    if (mi >= obs_ma.size()) chk(1'b0, req, "missing memory write", 0, longint'(a));
    else begin
      chk(obs_ma[mi] == a, req, "write address", longint'(obs_ma[mi]), longint'(a));
      chk(obs_md[mi] == d, req, "write data", longint'(obs_md[mi]), longint'(d));
    end
    mi++;
  endtask

  task automatic no_new(input string req);
    chk(obs_ra.size() == ri, req, "unexpected register writes", longint'(obs_ra.size()), longint'(ri));
    chk(obs_ma.size() == mi, req, "unexpected memory writes", longint'(obs_ma.size()), longint'(mi));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wptr = '0; wp = 0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    ri = obs_ra.size(); mi = obs_ma.size();
    chk(rptr == 0, "R1", "rptr after reset", longint'(rptr), 0);
    chk(!err && !paused && idle, "R1", "status after reset", {err, paused, idle}, 1);
    chk(!mem_req && !reg_we, "R1", "quiet after reset", {mem_req, reg_we}, 0);
  endtask

  initial begin
    int ts_ix;
    logic [31:0] rel_sel;
    do_reset();

    // R5: set-register, two data words
    emit(hdr(2'd3, 2, O_SET)); emit(32'h10); emit(32'hAAAA0001); emit(32'hAAAA0002);
    go(); settle();
    exp_reg(16'h10, 32'hAAAA0001, "R5");
    exp_reg(16'h11, 32'hAAAA0002, "R5");
    chk(rptr == 4, "R2", "rptr after set-register", longint'(rptr), 4);

    // R11: event write then acquire, no effects
    emit(hdr(2'd3, 0, O_EVT)); emit(32'hDEAD);
    emit(hdr(2'd3, 6, O_ACQ)); for (int i = 0; i < 7; i++) emit(32'h5A00 + 32'(i));
    go(); settle();
    chk(rptr == 14, "R11", "rptr after skips", longint'(rptr), 14);
    chk(!err, "R11", "no error on skips", longint'(err), 0);
    no_new("R11");

    // R8 / R2: release with value, packet wraps the ring end
    rel_sel = {3'd2, 29'd0};
    emit(hdr(2'd3, 6, O_REL)); emit(32'h05); emit(rel_sel); emit(32'h200); emit(32'h0);
    emit(32'h33334444); emit(32'h11112222); emit(32'h0);
    go(); settle();
    exp_mem(32'h200, 32'h33334444, "R8");
    exp_mem(32'h201, 32'h11112222, "R8");
    chk(rptr == 22, "R2", "rptr after wrapped packet", longint'(rptr), 22);

    // R6 / R7: memory wait, equal under mask, fails twice then passes
    put(32'h300, 32'h102);
    emit(hdr(2'd3, 5, O_WAIT)); emit(32'h13); emit(32'h300); emit(32'h0);
    emit(32'h5); emit(32'hFF); emit(32'h10);
    go(); settle();
    chk(paused, "R7", "paused after failed wait", longint'(paused), 1);
    chk(rptr == 22, "R7", "rptr rewound to header", longint'(rptr), 22);
    @(negedge clk); retry = 1'b1; @(negedge clk); retry = 1'b0;
    settle();
    chk(paused && rptr == 22, "R7", "still parked after failing retry", longint'(rptr), 22);
    put(32'h300, 32'h305);
    @(negedge clk); retry = 1'b1; @(negedge clk); retry = 1'b0;
    settle();
    chk(!paused && idle, "R6", "wait passed on masked equal", {paused, idle}, 1);
    chk(rptr == 29, "R6", "rptr after passing wait", longint'(rptr), 29);
    no_new("R6");

    // R6: immediate greater-or-equal
    emit(hdr(2'd3, 5, O_WAIT)); emit(32'h05); emit(32'h0); emit(32'h0);
    emit(32'h47); emit(32'hFF); emit(32'h0);
    go(); settle();
    chk(!paused && rptr == 36, "R6", "immediate GEQ passes", longint'(rptr), 36);

    // R10 / R9: indirect buffer with set-register and timestamp release
    to_ib = 1'b1; ib_wp = 32'h400;
    emit(hdr(2'd3, 1, O_SET)); emit(32'h20); emit(32'hCCCC0003);
    emit(hdr(2'd3, 6, O_REL)); emit(32'h14); emit({3'd3, 29'd0}); emit(32'h210);
    emit(32'h0); emit(32'h0); emit(32'h0); emit(32'h0);
    to_ib = 1'b0;
    emit(hdr(2'd3, 2, O_IB)); emit(32'h400); emit(32'h0); emit(32'hFF80000B);
    emit(hdr(2'd3, 1, O_SET)); emit(32'h30); emit(32'hDDDD0004);
    go(); settle();
    exp_reg(16'h20, 32'hCCCC0003, "R10");
    ts_ix = mi;
    if (obs_ma.size() >= mi + 2) begin
      chk(obs_ma[mi] == 32'h210 && obs_ma[mi+1] == 32'h211, "R9", "timestamp address",
          longint'(obs_ma[mi]), 32'h210);
      chk(obs_md[mi] != 0 && int'(obs_md[mi]) <= obs_mc[mi], "R9", "timestamp low in range",
          longint'(obs_md[mi]), longint'(obs_mc[mi]));
      chk(obs_md[mi+1] == 0, "R9", "timestamp high", longint'(obs_md[mi+1]), 0);
    end else chk(1'b0, "R9", "timestamp writes missing", longint'(obs_ma.size()), longint'(mi + 2));
    mi += 2;
    exp_reg(16'h30, 32'hDDDD0004, "R10");
    if (obs_rc.size() >= ri && obs_mc.size() > ts_ix + 1)
      chk(obs_rc[ri-1] > obs_mc[ts_ix+1], "R10", "ring resumed after buffer drained",
          longint'(obs_rc[ri-1]), longint'(obs_mc[ts_ix+1]));
    chk(rptr == 43 && idle, "R10", "rptr after indirect", longint'(rptr), 43);

    // R3: bad packet type halts
    emit(hdr(2'd2, 0, O_SET));
    emit(hdr(2'd3, 1, O_SET)); emit(32'h40); emit(32'hEEEE0005);
    go(); settle(); repeat (20) @(negedge clk);
    chk(err, "R3", "error on type 2", longint'(err), 1);
    chk(rptr == 44, "R3", "halted after bad header", longint'(rptr), 44);
    no_new("R3");

    // R4: unknown opcode
    do_reset();
    emit(hdr(2'd3, 0, 8'h11)); emit(hdr(2'd3, 0, O_EVT)); emit(32'h0);
    go(); settle(); repeat (10) @(negedge clk);
    chk(err && rptr == 1, "R4", "unknown opcode halts", longint'(rptr), 1);

    // R4: wait with wrong body count
    do_reset();
    emit(hdr(2'd3, 4, O_WAIT)); for (int i = 0; i < 5; i++) emit(32'h0);
    go(); settle();
    chk(err && rptr == 1, "R4", "bad wait count halts", longint'(rptr), 1);

    // R9: release selector 0 is an error
    do_reset();
    emit(hdr(2'd3, 6, O_REL)); emit(32'h14); emit(32'h0); emit(32'h220);
    emit(32'h0); emit(32'h1); emit(32'h2); emit(32'h0);
    go(); settle();
    chk(err && rptr == 8, "R9", "selector 0 halts", longint'(rptr), 8);
    no_new("R9");

    // R10: nested indirect is an error
    do_reset();
    to_ib = 1'b1; ib_wp = 32'h500;
    emit(hdr(2'd3, 2, O_IB)); emit(32'h600); emit(32'h0); emit(32'h3);
    to_ib = 1'b0;
    emit(hdr(2'd3, 2, O_IB)); emit(32'h500); emit(32'h0); emit(32'h4);
    go(); settle();
    chk(err && rptr == 4, "R10", "nested indirect halts", longint'(rptr), 4);
    no_new("R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk + mon_chk - n_fail - mon_fail, n_chk + mon_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk + mon_chk - n_fail - mon_fail, n_chk + mon_chk + 1);
      $finish;
    end
  end
endmodule